// File: doc/BRIEF.md
# Per-Pixel Hit Time-Stamp Store

This block holds the digital history of one pixel in a vertex detector that integrates over a whole bunch train and is read out in the quiet gap between trains. Whenever the pixel's comparator reports charge above threshold during the train, the block saves the current bunch-crossing number, protected by two parity bits, into the next free slot of a small local store. Offline analysis can then keep only the hits that share a single crossing, which keeps the effective occupancy very low even though the pixel is not read out for the whole train.

A crossing-number counter is built into the block. It runs only while the train gate is high, advances once per crossing strobe, and stops at its top value. The crossing strobe also marks the reset of the sensing node, so a comparator output that stays high for several clocks inside one crossing produces a single entry. After the train ends the store is frozen until the readout side pulses its clear input, which empties every slot and the overflow flag at once.

Top module: `pixel_stamp_store`

## Requirements
- R1: After reset, `hit_count` is 0, `overflow` is 0, every bit of `stamps` is 0 and `bx_time` is 0.
- R2: While `train_on` is low, `bx_time` reads 0 one cycle later. While `train_on` is high, each cycle with `bx_strobe` high raises `bx_time` by one in the following cycle, and otherwise it holds.
- R3: `bx_time` stops at its top value (4095 with the default 12-bit width) and stays there while the train lasts.
- R4: A cycle with `train_on` and `hit_in` high, `rd_clear` low, no entry yet taken in the current crossing and fewer than 4 entries stored writes slot number `hit_count` and raises `hit_count` by one in the next cycle. Slot i occupies `stamps[14*i+13 : 14*i]`; bits 11:0 of a slot hold the value `bx_time` had in the writing cycle.
- R5: Bit 12 of a stored slot is the XOR of the time bits at even positions (0, 2, ..., 10) and bit 13 is the XOR of the time bits at odd positions (1, 3, ..., 11).
- R6: At most one entry is written per crossing. A crossing ends with the cycle in which `bx_strobe` is high; a hit in that cycle carries the old time, and a hit in the next cycle may write a new entry with the incremented time.
- R7: While `train_on` is low, `hit_in` has no effect: `hit_count`, `stamps` and `overflow` hold.
- R8: A hit that would be accepted under R4 except that 4 entries are already stored changes no slot and no count, and sets `overflow`, which then stays high until a clear.
- R9: A cycle with `rd_clear` high makes `hit_count` 0, `overflow` 0 and every slot 0 in the next cycle; a hit in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_on | input | 1 | High for the duration of a bunch train |
| bx_strobe | input | 1 | One-cycle pulse closing the current crossing |
| hit_in | input | 1 | Comparator hit indication |
| rd_clear | input | 1 | Readout clear of all slots and the overflow flag |
| bx_time | output | 12 | Current crossing number |
| hit_count | output | 3 | Number of stored entries, 0 to 4 |
| stamps | output | 56 | All slots, slot i at bits 14*i+13 down to 14*i |
| overflow | output | 1 | Sticky flag: a hit was lost because the store was full |

## Verification
Two pairs of events can share one cycle here: a hit can coincide with the crossing strobe, and a hit can coincide with the readout clear. The bench drives a hit together with `bx_strobe` and then another hit in the very next cycle, and expects two entries carrying consecutive times, each with its own parity. It also raises `hit_in` in the same cycle as `rd_clear` and expects the store to come out empty, with the first later hit landing in slot 0.

// File: rtl/bx_counter.sv
module bx_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                    value <= '0;
    else if (!run)                 value <= '0;
    else if (step && value != TOP) value <= value + 1'b1;
  end
endmodule

// File: rtl/pixel_stamp_store.sv
module pixel_stamp_store #(
  parameter int DEPTH  = 4,
  parameter int TIME_W = 12,
  parameter int PAR_W  = 2,
  localparam int ENTRY_W = TIME_W + PAR_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       train_on,
  input  logic                       bx_strobe,
  input  logic                       hit_in,
  input  logic                       rd_clear,
  output logic [TIME_W-1:0]          bx_time,
  output logic [CNT_W-1:0]           hit_count,
  output logic [DEPTH*ENTRY_W-1:0]   stamps,
  output logic                       overflow
);
  function automatic logic [PAR_W-1:0] lane_parity(input logic [TIME_W-1:0] t);
    logic [PAR_W-1:0] p;
    p = '0;
    for (int i = 0; i < TIME_W; i++) p[i % PAR_W] = p[i % PAR_W] ^ t[i];
    return p;
  endfunction

  logic taken;
  logic full, attempt, wr_en;
  logic [ENTRY_W-1:0] new_entry;

  bx_counter #(.W(TIME_W)) u_time (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (train_on),
    .step  (bx_strobe),
    .value (bx_time)
  );

  assign full      = (hit_count == CNT_W'(DEPTH));
  assign attempt   = train_on & hit_in & ~taken & ~rd_clear;
  assign wr_en     = attempt & ~full;
  assign new_entry = {lane_parity(bx_time), bx_time};

  always_ff @(posedge clk) begin
    if (!rst_n)                     taken <= 1'b0;
    else if (!train_on || bx_strobe) taken <= 1'b0;
    else if (attempt)               taken <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rd_clear) hit_count <= '0;
    else if (wr_en)         hit_count <= hit_count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rd_clear)  overflow <= 1'b0;
    else if (attempt && full) overflow <= 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ENTRY_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (!rst_n || rd_clear)                        slot <= '0;
      else if (wr_en && hit_count == CNT_W'(g))      slot <= new_entry;
    end
    assign stamps[g*ENTRY_W +: ENTRY_W] = slot;
  end
endmodule

// File: rtl/stamp_store_chk.sv
module stamp_store_chk #(
  parameter int DEPTH  = 4,
  parameter int TIME_W = 12,
  parameter int PAR_W  = 2,
  localparam int ENTRY_W = TIME_W + PAR_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     train_on,
  input logic                     bx_strobe,
  input logic                     hit_in,
  input logic                     rd_clear,
  input logic [TIME_W-1:0]        bx_time,
  input logic [CNT_W-1:0]         hit_count,
  input logic [DEPTH*ENTRY_W-1:0] stamps,
  input logic                     overflow
);
  localparam logic [TIME_W-1:0] TOP = {TIME_W{1'b1}};

  // R2
  time_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !train_on |=> bx_time == '0);

  // R3
  time_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (train_on && bx_time == TOP) |=> bx_time == TOP);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clear |=> (hit_count == $past(hit_count)) ||
                  (hit_count == CNT_W'($past(hit_count) + 1'b1)));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count <= CNT_W'(DEPTH));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!train_on && !rd_clear) |=> $stable(hit_count) && $stable(stamps) && $stable(overflow));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !rd_clear) |=> overflow);

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear |=> (hit_count == '0) && !overflow && (stamps == '0));
endmodule

bind pixel_stamp_store stamp_store_chk #(
  .DEPTH(DEPTH), .TIME_W(TIME_W), .PAR_W(PAR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .train_on(train_on), .bx_strobe(bx_strobe),
  .hit_in(hit_in), .rd_clear(rd_clear), .bx_time(bx_time),
  .hit_count(hit_count), .stamps(stamps), .overflow(overflow)
);

// File: tb/tb_pixel_stamp_store.sv
module tb_pixel_stamp_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_on = 1'b0, bx_strobe = 1'b0, hit_in = 1'b0, rd_clear = 1'b0;
  logic [11:0] bx_time;
  logic [2:0]  hit_count;
  logic [55:0] stamps;
  logic        overflow;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  pixel_stamp_store dut (
    .clk(clk), .rst_n(rst_n), .train_on(train_on), .bx_strobe(bx_strobe),
    .hit_in(hit_in), .rd_clear(rd_clear), .bx_time(bx_time),
    .hit_count(hit_count), .stamps(stamps), .overflow(overflow)
  );

  function automatic logic [13:0] ent(input logic [11:0] t);
    logic pe, po;
    pe = t[0] ^ t[2] ^ t[4] ^ t[6] ^ t[8] ^ t[10];
    po = t[1] ^ t[3] ^ t[5] ^ t[7] ^ t[9] ^ t[11];
    return {po, pe, t};
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs at a falling edge; outputs are stable at the next falling edge
  task automatic cyc(input logic tr, input logic hit, input logic stb, input logic clr);
    train_on = tr; hit_in = hit; bx_strobe = stb; rd_clear = clr;
    @(negedge clk);
    hit_in = 1'b0; bx_strobe = 1'b0; rd_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "hit_count", hit_count, 0);
    check("R1", "overflow", overflow, 0);
    check("R1", "stamps", stamps, 0);
    check("R1", "bx_time", bx_time, 0);
  endtask

  task automatic t_counter();
    cyc(1, 0, 0, 0);
    check("R2", "time at train start", bx_time, 0);
    for (int i = 0; i < 7; i++) cyc(1, 0, 1, 0);
    check("R2", "time after 7 strobes", bx_time, 7);
    cyc(1, 0, 0, 0);
    check("R2", "time holds without strobe", bx_time, 7);
    cyc(0, 0, 1, 0);
    check("R2", "time with train off", bx_time, 0);
  endtask

  task automatic t_saturate();
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 4100; i++) cyc(1, 0, 1, 0);
    check("R3", "saturated time", bx_time, 4095);
    cyc(1, 0, 1, 0);
    check("R3", "time stays at top", bx_time, 4095);
    cyc(0, 0, 0, 0);
  endtask

  task automatic t_hits();
    logic [55:0] exp;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0);
    cyc(1, 1, 0, 0);
    check("R4", "count after first hit", hit_count, 1);
    cyc(1, 1, 0, 0);
    cyc(1, 1, 0, 0);
    check("R6", "held hit writes once", hit_count, 1);
    check("R5", "slot0 stamp time 5", stamps[13:0], ent(12'd5));
    cyc(1, 0, 1, 0);
    cyc(1, 1, 1, 0);
    check("R6", "hit with strobe old time", stamps[27:14], ent(12'd6));
    check("R2", "time after strobe", bx_time, 7);
    cyc(1, 1, 0, 0);
    check("R6", "hit right after strobe", hit_count, 3);
    check("R5", "slot2 stamp time 7", stamps[41:28], ent(12'd7));
    for (int i = 0; i < 2741; i++) cyc(1, 0, 1, 0);
    check("R2", "time reached 0xABC", bx_time, 12'hABC);
    cyc(1, 1, 0, 0);
    check("R4", "count at full", hit_count, 4);
    check("R5", "slot3 stamp 0xABC", stamps[55:42], ent(12'hABC));
    exp = stamps;
    cyc(1, 0, 1, 0);
    cyc(1, 1, 0, 0);
    check("R8", "overflow set", overflow, 1);
    check("R8", "count unchanged", hit_count, 4);
    check("R8", "stamps unchanged", stamps, exp);
    cyc(1, 0, 1, 0);
    cyc(1, 0, 0, 0);
    check("R8", "overflow sticky", overflow, 1);
    cyc(0, 0, 0, 0);
    cyc(0, 1, 1, 0);
    cyc(0, 1, 0, 0);
    check("R7", "count with train off", hit_count, 4);
    check("R7", "stamps with train off", stamps, exp);
    check("R7", "overflow with train off", overflow, 1);
  endtask

  task automatic t_clear();
    cyc(0, 1, 0, 0);
    cyc(1, 1, 0, 1);
    check("R9", "count after clear", hit_count, 0);
    check("R9", "overflow after clear", overflow, 0);
    check("R9", "stamps after clear", stamps, 0);
    cyc(1, 0, 1, 0);
    cyc(1, 1, 0, 0);
    check("R9", "first hit after clear lands in slot0", hit_count, 1);
    check("R5", "slot0 stamp time 1", stamps[13:0], ent(12'd1));
    check("R9", "other slots empty", stamps[55:14], 0);
    cyc(0, 0, 0, 1);
    check("R9", "clear with train off", hit_count, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counter();
    t_saturate();
    t_hits();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule